// File: doc/BRIEF.md
# Watchdog Timer with Guarded Turn-Off

This block is a watchdog counter that advances only on cycles where a slow tick enable is high, so the slow oscillator that paces it is represented by a one-cycle enable on the system clock. Software selects one of eight timeout lengths with a 3-bit period code. It keeps the watchdog from firing by pulsing the restart input before the count reaches the selected length. If the count does reach that length while the watchdog is enabled, the block emits a single-clock reset pulse and starts counting again from zero.

The configuration is written through a plain write strobe that carries an enable bit, a turn-off-enable bit and the period code. Setting the enable bit is always accepted. Clearing it takes a guarded two-write sequence. The first write sets both the enable bit and the turn-off-enable bit, which opens a short window. The second write clears the enable bit while keeping turn-off-enable set, and it must land inside that window. Any other attempt to clear the enable bit is ignored. The stored control state is driven out on status pins.

Top module: `wdog_guard`

## Requirements
- R1: After reset, st_en, st_toe and wd_rst are 0 and st_psel is 0.
- R2: With the watchdog enabled and period code p, wd_rst goes high in the clock cycle after the edge that takes the 2^(BASE_EXP+p)-th counted tick since the counter was last zero. By default BASE_EXP is 14, so codes 0 to 7 give 2^14 to 2^21 ticks.
- R3: A clock edge with slow_tick low does not advance the count.
- R4: wd_rst is high for exactly one clock. The count restarts from zero, so the next pulse follows another full period.
- R5: A kick sampled at a clock edge sets the count to zero, and kick takes priority over a tick at the same edge.
- R6: While st_en is 0, the count does not advance and wd_rst stays low.
- R7: A write with cfg_en=1 and cfg_toe=1 sets st_en and st_toe. st_toe stays high for WIN clocks (default 4) and then clears by itself.
- R8: A write with cfg_en=0 and cfg_toe=1, sampled while st_toe is 1, clears both st_en and st_toe. This is the only way st_en falls.
- R9: A write with cfg_en=0 is ignored for st_en if cfg_toe is 0 or the window has closed. Any write with cfg_toe=0 closes the window.
- R10: Every write loads st_psel from cfg_psel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | One-cycle enable standing for a slow-oscillator tick |
| kick | input | 1 | Restart strobe; clears the count |
| cfg_wr | input | 1 | Control write strobe |
| cfg_en | input | 1 | Enable bit carried by the write |
| cfg_toe | input | 1 | Turn-off-enable bit carried by the write |
| cfg_psel | input | 3 | Period code carried by the write |
| wd_rst | output | 1 | One-clock timeout reset pulse |
| st_en | output | 1 | Stored enable bit |
| st_toe | output | 1 | Turn-off window open |
| st_psel | output | 3 | Stored period code |

## Verification
The hardest state to reach from the ports is the exact edge of the turn-off window. To hit it, the bench issues the arming write and waits a counted number of idle clocks. It then places the disable write on the last edge where the window is still open, and again on the first edge after it has closed. Each outcome is read from st_en, and in the rejected case the bench also confirms that a timeout pulse still arrives. The bench builds the block with a small BASE_EXP so that all eight period codes can be measured tick by tick, with both continuous and gapped tick patterns.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int PSEL_W = 3;
  localparam int NCODE  = 1 << PSEL_W;

  typedef logic [PSEL_W-1:0] psel_t;

  typedef struct packed {
    logic  en;
    logic  toe;
    psel_t psel;
  } cfg_req_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int WIN = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr,
  input  cfg_req_t req,
  output logic     en_q,
  output logic     toe_q,
  output psel_t    psel_q
);
  localparam int WIN_W = $clog2(WIN + 1);

  logic [WIN_W-1:0] win_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      toe_q   <= 1'b0;
      psel_q  <= '0;
      win_cnt <= '0;
    end else if (wr) begin
      psel_q <= req.psel;
      if (req.en) begin
        en_q <= 1'b1;
        if (req.toe) begin
          toe_q   <= 1'b1;
          win_cnt <= WIN_W'(WIN - 1);
        end else begin
          toe_q <= 1'b0;
        end
      end else begin
        if (req.toe && toe_q) begin
          en_q <= 1'b0;
        end
        toe_q <= 1'b0;
      end
    end else if (toe_q) begin
      if (win_cnt == '0) toe_q <= 1'b0;
      else               win_cnt <= win_cnt - 1'b1;
    end
  end

  assert_toe_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(toe_q) |-> $past(wr && req.en && req.toe));

  assert_disable_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |-> $past(wr && !req.en && req.toe && toe_q));

  assert_en_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && wr && !req.toe) |=> en_q);
endmodule

// File: rtl/wdog_tap.sv
module wdog_tap
  import wdog_pkg::*;
#(
  parameter int BASE_EXP = 14,
  parameter int CNT_W    = BASE_EXP + NCODE - 1
) (
  input  logic [CNT_W-1:0] cnt,
  input  psel_t            psel,
  output logic             hit
);
  logic [NCODE-1:0] hits;

  for (genvar i = 0; i < NCODE; i++) begin : g_tap
    assign hits[i] = &cnt[BASE_EXP+i-1:0];
  end

  assign hit = hits[psel];
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int BASE_EXP = 14,
  parameter int CNT_W    = BASE_EXP + NCODE - 1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run,
  input  logic  tick,
  input  logic  kick,
  input  psel_t psel,
  output logic  pulse
);
  logic [CNT_W-1:0] cnt;
  logic             hit;

  wdog_tap #(.BASE_EXP(BASE_EXP), .CNT_W(CNT_W)) u_tap (
    .cnt  (cnt),
    .psel (psel),
    .hit  (hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= run && !kick && tick && hit;
      if (!run || kick)  cnt <= '0;
      else if (tick) begin
        if (hit) cnt <= '0;
        else     cnt <= cnt + 1'b1;
      end
    end
  end

  assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);

  assert_kick_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && kick) |=> (cnt == '0));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick && !kick) |=> $stable(cnt));
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
  import wdog_pkg::*;
#(
  parameter int BASE_EXP = 14,
  parameter int WIN      = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slow_tick,
  input  logic       kick,
  input  logic       cfg_wr,
  input  logic       cfg_en,
  input  logic       cfg_toe,
  input  logic [2:0] cfg_psel,
  output logic       wd_rst,
  output logic       st_en,
  output logic       st_toe,
  output logic [2:0] st_psel
);
  localparam int CNT_W = BASE_EXP + NCODE - 1;

  cfg_req_t req;
  psel_t    psel_q;

  assign req.en   = cfg_en;
  assign req.toe  = cfg_toe;
  assign req.psel = cfg_psel;

  wdog_ctrl #(.WIN(WIN)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (cfg_wr),
    .req    (req),
    .en_q   (st_en),
    .toe_q  (st_toe),
    .psel_q (psel_q)
  );

  wdog_count #(.BASE_EXP(BASE_EXP), .CNT_W(CNT_W)) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (st_en),
    .tick  (slow_tick),
    .kick  (kick),
    .psel  (psel_q),
    .pulse (wd_rst)
  );

  assign st_psel = psel_q;

  assert_pulse_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst |-> $past(st_en));

  assert_psel_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (st_psel == $past(cfg_psel)));
endmodule

// File: tb/wdog_guard_tb.sv
`timescale 1ns/1ps
module wdog_guard_tb;
  localparam int BE  = 3;
  localparam int WIN = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slow_tick = 1'b0;
  logic       kick = 1'b0;
  logic       cfg_wr = 1'b0;
  logic       cfg_en = 1'b0;
  logic       cfg_toe = 1'b0;
  logic [2:0] cfg_psel = 3'd0;
  logic       wd_rst, st_en, st_toe;
  logic [2:0] st_psel;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  wdog_guard #(.BASE_EXP(BE), .WIN(WIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .kick(kick),
    .cfg_wr(cfg_wr), .cfg_en(cfg_en), .cfg_toe(cfg_toe), .cfg_psel(cfg_psel),
    .wd_rst(wd_rst), .st_en(st_en), .st_toe(st_toe), .st_psel(st_psel)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input bit en, input bit toe, input int ps);
    cfg_wr = 1'b1; cfg_en = en; cfg_toe = toe; cfg_psel = 3'(ps);
    @(posedge clk); @(negedge clk);
    cfg_wr = 1'b0; cfg_en = 1'b0; cfg_toe = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  // Count ticked edges until wd_rst is seen; mode 1 ticks every other cycle.
  task automatic measure(input int exp_t, input int mode, input string tag);
    int ticks = 0;
    int n = 0;
    bit got = 0;
    while (!got && n < 4 * exp_t + 20) begin
      slow_tick = (mode == 0) ? 1'b1 : ((n % 2) == 0);
      @(posedge clk);
      if (slow_tick) ticks++;
      @(negedge clk);
      n++;
      if (wd_rst) got = 1;
    end
    slow_tick = 1'b0;
    check(got && ticks == exp_t, tag, got ? ticks : -1, exp_t);
    @(posedge clk); @(negedge clk);
    check(!wd_rst, {tag, " R4 pulse width"}, wd_rst, 0);
  endtask

  task automatic run_quiet(input int n, input string tag);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      slow_tick = 1'b1;
      @(posedge clk); @(negedge clk);
      if (wd_rst) seen = 1;
    end
    slow_tick = 1'b0;
    check(!seen, tag, seen, 0);
  endtask

  task automatic t_reset();
    check(st_en == 0 && st_toe == 0 && wd_rst == 0, "R1 reset flags",
          {st_en, st_toe, wd_rst}, 0);
    check(st_psel == 0, "R1 reset psel", st_psel, 0);
  endtask

  task automatic t_basic();
    wr(1, 0, 0);
    check(st_en == 1, "R10 enable set", st_en, 1);
    measure(1 << BE, 0, "R2 code0 period");
    measure(1 << BE, 0, "R4 second period after restart");
  endtask

  task automatic t_all_codes();
    for (int p = 0; p < 8; p++) begin
      wr(1, 0, p);
      check(st_psel == 3'(p), "R10 psel load", st_psel, p);
      measure(1 << (BE + p), 0, "R2 period per code");
    end
  endtask

  task automatic t_gapped();
    wr(1, 0, 1);
    measure(1 << (BE + 1), 1, "R3 gapped ticks");
  endtask

  task automatic t_kick();
    wr(1, 0, 2);
    run_quiet(20, "R5 before kick");
    kick = 1'b1; slow_tick = 1'b1;
    @(posedge clk); @(negedge clk);
    kick = 1'b0; slow_tick = 1'b0;
    run_quiet(28, "R5 no pulse within fresh period");
    measure((1 << (BE + 2)) - 28, 0, "R5 remainder after kick");
  endtask

  task automatic t_window();
    int hi = 0;
    wr(1, 1, 0);
    for (int i = 0; i < WIN; i++) begin
      if (st_toe) hi++;
      idle(1);
    end
    check(hi == WIN, "R7 window length", hi, WIN);
    check(st_toe == 0, "R7 window self clear", st_toe, 0);
  endtask

  task automatic t_late();
    wr(1, 1, 0);
    idle(WIN);
    wr(0, 1, 0);
    check(st_en == 1, "R9 late disable ignored", st_en, 1);
    measure(1 << BE, 0, "R9 still times out");
  endtask

  task automatic t_toe_zero();
    wr(1, 1, 0);
    wr(0, 0, 0);
    check(st_en == 1 && st_toe == 0, "R9 toe=0 write in window", {st_en, st_toe}, 2);
    wr(0, 1, 0);
    check(st_en == 1, "R9 window closed by toe=0 write", st_en, 1);
  endtask

  task automatic t_disable();
    wr(1, 1, 0);
    idle(WIN - 1);
    wr(0, 1, 0);
    check(st_en == 0 && st_toe == 0, "R8 disable on last window edge", {st_en, st_toe}, 0);
    run_quiet(40, "R6 no pulse while disabled");
    kick = 1'b1; @(posedge clk); @(negedge clk); kick = 1'b0;
    check(st_en == 0 && wd_rst == 0, "R6 kick while disabled", {st_en, wd_rst}, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_basic();
    t_all_codes();
    t_gapped();
    t_kick();
    t_window();
    t_late();
    t_toe_zero();
    t_disable();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule